// File: doc/BRIEF.md
# ECC Sector Error-Count Scanner

After a page has been read through a hardware ECC decoder, the decoder leaves its per-sector error counts in a bank of 32-bit status words. This block walks the sectors that belong to one page buffer and reduces their counts to one result. The result is the total number of corrected bits and a flag that is set if any sector could not be corrected. A controller pulses `start` with the buffer number and the number of ECC steps per page. The block then reads the status words it needs through a simple read port with one cycle of latency. When it is finished it raises `done` for one cycle.

Each status word packs four sectors. Each sector owns one byte, and only the low 4 bits of that byte carry the count. The lowest-numbered sector of a word sits in the most significant byte. The count value 15 is reserved and means the sector is uncorrectable.

The controller is a five-state machine:
- **S_IDLE** waits for `start`. On start it goes to **S_FETCH**, or straight to **S_FINISH** when the step count is zero.
- **S_FETCH** issues a read of the word that holds the current sector, then goes to **S_LOAD**.
- **S_LOAD** captures the returned word, then goes to **S_SCAN**.
- **S_SCAN** handles one sector per cycle. It goes to **S_FINISH** after the last sector. It goes back to **S_FETCH** when the next sector starts a new word. Otherwise it stays in **S_SCAN**.
- **S_FINISH** drives `done` and returns to **S_IDLE**.

Top module: `ecc_sector_scan`

## Requirements
- R1: After reset, `done`, `rd_en`, `uncorrectable` and `corr_total` are all 0.
- R2: Sector i is read from word address floor(i/4). Its count is in bits [(3 - i mod 4)*8 + 3 : (3 - i mod 4)*8] of that word. The upper 4 bits of each byte are ignored.
- R3: The scan covers exactly `start_steps` consecutive sectors. The first of them is `start_buf * start_steps`.
- R4: A count of 15 sets `uncorrectable` and adds nothing to `corr_total`.
- R5: Every count from 0 to 14 in the scanned range is added to `corr_total`.
- R6: Each status word the range touches is read exactly once, as a one-cycle `rd_en` pulse with `rd_addr` = word address. The first read is of the starting sector's word. The bench returns data on `rd_data` in the cycle after the read.
- R7: `done` is high for exactly one cycle after the last sector has been handled. `corr_total` and `uncorrectable` then hold their values until the next accepted start.
- R8: An accepted start clears the previous total and flag before the new scan accumulates.
- R9: A `start` that arrives while a scan is in progress is ignored. It changes neither the range nor the result, and it produces no second `done`.
- R10: A start with `start_steps` = 0 produces a `done` pulse with a zero total and no flag, and issues no reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Scan request, sampled while idle |
| start_buf | input | 4 | Page buffer number |
| start_steps | input | 5 | ECC steps per page (0 to 16) |
| rd_en | output | 1 | Status word read strobe |
| rd_addr | output | 6 | Status word address |
| rd_data | input | 32 | Status word, valid the cycle after `rd_en` |
| corr_total | output | 8 | Sum of corrected-bit counts |
| uncorrectable | output | 1 | Some sector reported the value 15 |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong sector index shows up first at `rd_addr`: the first read strobe arrives one cycle after `start` and carries the wrong word address. It shows up again in `corr_total` when `done` fires. A wrong lane selection or a wrong word-crossing decision changes the number of read strobes or the total within the same scan. A fault in the accumulator, such as a stale clear or an added 15, is visible in `corr_total` or `uncorrectable` at the first `done`. A fault in the state sequencing shows as a missing, early or repeated `done` pulse, within a few cycles of the expected finish.

// File: rtl/ecc_scan_pkg.sv
package ecc_scan_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_LOAD,
        S_SCAN,
        S_FINISH
    } scan_state_t;
endpackage

// File: rtl/ecc_nibble_pick.sv
module ecc_nibble_pick #(
    parameter int WORD_W = 32,
    parameter int LANES  = 4,
    parameter int NIB_W  = 4,
    localparam int LANE_W = $clog2(LANES),
    localparam int BYTE_W = WORD_W / LANES
) (
    input  logic [WORD_W-1:0] word,
    input  logic [LANE_W-1:0] lane,
    output logic [NIB_W-1:0]  nib
);
    logic [NIB_W-1:0] lane_nib [LANES];

    // The lowest lane number maps to the most significant byte.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lane_nib[k] = word[(LANES-1-k)*BYTE_W +: NIB_W];
    end

    assign nib = lane_nib[lane];
endmodule

// File: rtl/ecc_scan_accum.sv
module ecc_scan_accum #(
    parameter int NIB_W = 4,
    parameter int SUM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             en,
    input  logic [NIB_W-1:0] nib,
    output logic [SUM_W-1:0] total,
    output logic             flag
);
    localparam logic [NIB_W-1:0] BAD_CODE = {NIB_W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            total <= '0;
            flag  <= 1'b0;
        end else if (clear) begin
            total <= '0;
            flag  <= 1'b0;
        end else if (en) begin
            if (nib == BAD_CODE) flag <= 1'b1;
            else                 total <= total + SUM_W'(nib);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clear && nib != BAD_CODE) |-> ({1'b0, total} + (SUM_W+1)'(nib)) < (SUM_W+1)'(2**SUM_W)); // R5
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clear) |=> flag); // R4
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (total == '0 && !flag)); // R8
    AST_BAD_NOT_ADDED: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clear && nib == BAD_CODE) |=> $stable(total)); // R4
endmodule

// File: rtl/ecc_sector_scan.sv
module ecc_sector_scan
    import ecc_scan_pkg::*;
#(
    parameter int BUF_W  = 4,
    parameter int STEP_W = 5,
    parameter int IDX_W  = 8,
    parameter int WORD_W = 32,
    parameter int LANES  = 4,
    parameter int NIB_W  = 4,
    parameter int SUM_W  = 8,
    localparam int LANE_W = $clog2(LANES),
    localparam int ADDR_W = IDX_W - LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BUF_W-1:0]  start_buf,
    input  logic [STEP_W-1:0] start_steps,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [WORD_W-1:0] rd_data,
    output logic [SUM_W-1:0]  corr_total,
    output logic              uncorrectable,
    output logic              done
);
    scan_state_t state_q, state_d;

    logic [IDX_W-1:0]        idx_q, last_q;
    logic [WORD_W-1:0]       word_q;
    logic [BUF_W+STEP_W-1:0] first_prod;
    logic [IDX_W-1:0]        first_idx, last_idx;
    logic                    accept, acc_en;
    logic [NIB_W-1:0]        cur_nib;
    logic                    word_end;

    assign first_prod = (BUF_W+STEP_W)'(start_buf) * (BUF_W+STEP_W)'(start_steps);
    assign first_idx  = first_prod[IDX_W-1:0];
    assign last_idx   = first_idx + IDX_W'(start_steps) - IDX_W'(1);
    assign word_end   = (idx_q[LANE_W-1:0] == LANE_W'(LANES-1));

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start) state_d = (start_steps == '0) ? S_FINISH : S_FETCH;
            S_FETCH:  state_d = S_LOAD;
            S_LOAD:   state_d = S_SCAN;
            S_SCAN: begin
                if (idx_q == last_q) state_d = S_FINISH;
                else if (word_end)   state_d = S_FETCH;
                else                 state_d = S_SCAN;
            end
            S_FINISH: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // State register and sector datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            idx_q   <= '0;
            last_q  <= '0;
            word_q  <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                idx_q  <= first_idx;
                last_q <= last_idx;
            end
            if (state_q == S_LOAD) word_q <= rd_data;
            if (state_q == S_SCAN && idx_q != last_q) idx_q <= idx_q + IDX_W'(1);
        end
    end

    // Outputs decoded from the state
    always_comb begin
        accept = (state_q == S_IDLE) && start;
        rd_en  = (state_q == S_FETCH);
        acc_en = (state_q == S_SCAN);
        done   = (state_q == S_FINISH);
    end

    assign rd_addr = idx_q[IDX_W-1:LANE_W];

    ecc_nibble_pick #(
        .WORD_W (WORD_W),
        .LANES  (LANES),
        .NIB_W  (NIB_W)
    ) u_pick (
        .word (word_q),
        .lane (idx_q[LANE_W-1:0]),
        .nib  (cur_nib)
    );

    ecc_scan_accum #(
        .NIB_W (NIB_W),
        .SUM_W (SUM_W)
    ) u_accum (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (accept),
        .en    (acc_en),
        .nib   (cur_nib),
        .total (corr_total),
        .flag  (uncorrectable)
    );

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_READ_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> !rd_en); // R6
    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && !start) |=> ($stable(corr_total) && $stable(uncorrectable))); // R7
    AST_ZERO_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && start && start_steps == '0) |=> (done && !rd_en)); // R10
    AST_BUSY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE) |=> $stable(last_q)); // R9
endmodule

// File: tb/ecc_sector_scan_test.sv
module ecc_sector_scan_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  start_buf = '0;
    logic [4:0]  start_steps = '0;
    logic        rd_en;
    logic [5:0]  rd_addr;
    logic [31:0] rd_data = '0;
    logic [7:0]  corr_total;
    logic        uncorrectable;
    logic        done;

    int checks = 0;
    int failures = 0;
    int reads = 0;
    int first_addr = -1;
    int cycles = 0;
    logic [31:0] mem [64];

    always #4 clk = ~clk;

    ecc_sector_scan uut (
        .clk (clk), .rst_n (rst_n), .start (start), .start_buf (start_buf),
        .start_steps (start_steps), .rd_en (rd_en), .rd_addr (rd_addr),
        .rd_data (rd_data), .corr_total (corr_total),
        .uncorrectable (uncorrectable), .done (done)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (rd_en) begin
            rd_data <= mem[rd_addr];
            if (reads == 0) first_addr = int'(rd_addr);
            reads = reads + 1;
        end
    end

    initial begin
        #(8 * 100000);
        failures++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int nib_of(input int i);
        logic [31:0] w;
        w = mem[i / 4];
        return int'(w[(3 - i % 4) * 8 +: 4]);
    endfunction

    task automatic model(input int b, input int s, output int tot, output int unc, output int nrd);
        tot = 0; unc = 0; nrd = 0;
        for (int i = b * s; i < b * s + s; i++) begin
            if (nib_of(i) == 15) unc = 1;
            else tot += nib_of(i);
        end
        if (s > 0) nrd = ((b * s + s - 1) / 4) - ((b * s) / 4) + 1;
    endtask

    task automatic pulse_start(input int b, input int s);
        @(negedge clk);
        start = 1'b1; start_buf = 4'(b); start_steps = 5'(s);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_scan(input string tag, input int b, input int s, input int late_b);
        int tot, unc, nrd, wait_n, seen;
        model(b, s, tot, unc, nrd);
        reads = 0; first_addr = -1; seen = 0;
        @(negedge clk);
        start = 1'b1; start_buf = 4'(b); start_steps = 5'(s);
        @(negedge clk);
        start = 1'b0;
        wait_n = 0;
        while (!done && wait_n < 200) begin
            if (late_b >= 0 && wait_n == 2) begin
                start = 1'b1; start_buf = 4'(late_b); start_steps = 5'(s);
            end else start = 1'b0;
            @(negedge clk);
            wait_n++;
        end
        start = 1'b0;
        check(done == 1'b1, {tag, " R7 done seen"}, int'(done), 1);
        check(int'(corr_total) == tot, {tag, " R5 R3 total"}, int'(corr_total), tot);
        check(int'(uncorrectable) == unc, {tag, " R4 flag"}, int'(uncorrectable), unc);
        check(reads == nrd, {tag, " R6 read count"}, reads, nrd);
        if (s > 0)
            check(first_addr == (b * s) / 4, {tag, " R2 first address"}, first_addr, (b * s) / 4);
        @(negedge clk);
        check(done == 1'b0, {tag, " R7 single pulse"}, int'(done), 0);
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (done) seen++;
        end
        check(seen == 0, {tag, " R9 no extra done"}, seen, 0);
        check(int'(corr_total) == tot && int'(uncorrectable) == unc,
              {tag, " R7 hold"}, int'(corr_total), tot);
    endtask

    task automatic t_reset();
        check(done == 0 && rd_en == 0, "R1 done/rd_en", int'(done) + int'(rd_en), 0);
        check(corr_total == 0 && uncorrectable == 0, "R1 result", int'(corr_total), 0);
    endtask

    task automatic t_aligned();   run_scan("aligned", 0, 4, -1); endtask
    task automatic t_straddle();  run_scan("straddle", 1, 3, -1); endtask
    task automatic t_odd();       run_scan("odd", 3, 5, -1); endtask

    task automatic t_uncorr();
        mem[5][15:12] = 4'h3;
        mem[5][11:8]  = 4'hF;   // R4: sector 22 reports 15
        run_scan("uncorr", 5, 4, -1);
        check(uncorrectable == 1'b1, "R4 flag set", int'(uncorrectable), 1);
    endtask

    task automatic t_clear();
        run_scan("clear", 0, 4, -1);   // R8: previous flag must be cleared
        check(uncorrectable == 1'b0, "R8 flag cleared", int'(uncorrectable), 0);
    endtask

    task automatic t_max();
        for (int w = 60; w < 64; w++) mem[w] = 32'hAEAEAEAE;
        run_scan("max", 15, 16, -1);
        check(corr_total == 8'd224, "R5 max total", int'(corr_total), 224);
    endtask

    task automatic t_zero();
        run_scan("zero", 7, 0, -1);    // R10
        check(reads == 0, "R10 no reads", reads, 0);
    endtask

    task automatic t_busy_start();
        run_scan("busy", 2, 4, 9);     // R9: late start on buffer 9 ignored
    endtask

    initial begin
        for (int w = 0; w < 64; w++)
            for (int b = 0; b < 4; b++)
                mem[w][b*8 +: 8] = {4'hA, 4'((w * 7 + b * 3) % 15)};
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_aligned();
        t_straddle();
        t_odd();
        t_uncorr();
        t_clear();
        t_max();
        t_zero();
        t_busy_start();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule